// File: doc/BRIEF.md
# Carry-free radix-4 Booth recoder for a sum of two operands

This block takes two operands of equal width and produces the radix-4 signed-digit (Modified Booth) form of their sum, with no carry-propagate adder in the path. Each recoding cell looks at a two-bit slice of both operands. It also takes two single-bit carries from the cell just below. It returns one digit in the range -2 to +2 and two carries for the cell above. A carry never travels more than one cell, so the logic depth is the same at every width. The digits feed a Booth partial-product stage directly, which lets an add-then-multiply datapath skip the intermediate binary sum.

The operand type is fixed by a parameter: signed two's complement or unsigned, at any odd or even width. In signed mode the most significant cell treats its upper bit pair as negatively weighted. In unsigned mode every cell is a plain one, and the operands are zero-extended far enough that no carry leaves the top. Each digit is presented as three select bits (magnitude one, magnitude two, negate), captured in a register stage.

Top module: `smb_recoder`

## Requirements
- R1: The number of digits ND is floor((WIDTH+2)/2) for signed operands and floor((WIDTH+3)/2) for unsigned ones. Bit j of each select output belongs to digit j, and digit j has weight 4^j.
- R2: In signed mode the sum over j of digit_j times 4^j equals the two's complement sum of a_i and b_i, for every input pair.
- R3: In unsigned mode the sum over j of digit_j times 4^j equals the unsigned sum of a_i and b_i, for every input pair, and no carry is lost out of the top cell.
- R4: A digit's magnitude is 1 when its one_o bit is set and 2 when its two_o bit is set. Its sign is negative when its neg_o bit is set. one_o and two_o are never both set for the same digit.
- R5: A digit of value zero has all three select bits low. In particular, neg_o is never set for a zero digit.
- R6: In unsigned mode the most significant digit is never negative.
- R7: Digit j depends only on operand bits 2j-3 through 2j+1 of both operands. Changing bits outside that window leaves digit j unchanged.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears all select outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| one_o | output | ND | Per-digit flag: magnitude 1 |
| two_o | output | ND | Per-digit flag: magnitude 2 |
| neg_o | output | ND | Per-digit flag: negative digit |

## Verification
The bench builds four copies of the recoder: signed at widths 4 and 5, and unsigned at widths 4 and 5. Together they cover both parity cases in both operand modes, including the signed top cell and the unsigned width that needs an extra digit. At these widths every operand pair is swept exhaustively, so the extreme sums that fill the top digit are reached, along with every carry combination between cells. A targeted sweep flips bits outside a digit's input window to show the carry chain is bounded.

// File: rtl/smb_pkg.sv
package smb_pkg;

  // Select bits describing one radix-4 digit
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_sel_t;

  // Digits needed to hold the sum without overflow
  function automatic int digit_count(input int width, input bit is_signed);
    return is_signed ? (width + 2) / 2 : (width + 3) / 2;
  endfunction

endpackage

// File: rtl/smb_plain_cell.sv
// Recoding cell with all four input bits positively weighted.
module smb_plain_cell (
  input  logic              a_lo,
  input  logic              a_hi,
  input  logic              b_lo,
  input  logic              b_hi,
  input  logic              hc_in,   // half-adder carry from the cell below
  input  logic              k_in,    // signed-adder carry from the cell below
  output logic              hc_out,
  output logic              k_out,
  output logic signed [2:0] digit_o
);
  logic hs, fs, fc, neg;

  // Half adder on the upper pair: its carry leaves for the next cell
  assign hs     = a_hi ^ b_hi;
  assign hc_out = a_hi & b_hi;

  // Full adder on the lower pair plus the incoming half-adder carry
  assign fs = a_lo ^ b_lo ^ hc_in;
  assign fc = (a_lo & b_lo) | (a_lo & hc_in) | (b_lo & hc_in);

  // Signed half adder: hs + fc = 2*k_out - neg
  assign k_out = hs | fc;
  assign neg   = hs ^ fc;

  // digit = -2*neg + fs + k_in
  assign digit_o = (neg ? 3'sb110 : 3'sb000) + $signed({2'b00, fs}) + $signed({2'b00, k_in});
endmodule

// File: rtl/smb_signed_top_cell.sv
// Most significant cell for signed operands: the upper pair carries weight -2.
module smb_signed_top_cell (
  input  logic              a_lo,
  input  logic              a_hi,
  input  logic              b_lo,
  input  logic              b_hi,
  input  logic              hc_in,
  input  logic              k_in,
  output logic signed [2:0] digit_o
);
  logic lo_s, lo_c;

  // Positive half adder on the lower pair
  assign lo_s = a_lo ^ b_lo;
  assign lo_c = a_lo & b_lo;

  // Sum of weighted bits; the result always lies in [-2, 2]
  assign digit_o = $signed({2'b00, lo_s}) + $signed({1'b0, lo_c, 1'b0})
                 - $signed({1'b0, a_hi, 1'b0}) - $signed({1'b0, b_hi, 1'b0})
                 + $signed({2'b00, hc_in}) + $signed({2'b00, k_in});
endmodule

// File: rtl/smb_digit_enc.sv
// Turns a signed digit in [-2, 2] into select bits.
module smb_digit_enc (
  input  logic signed [2:0]  digit_i,
  output smb_pkg::booth_sel_t sel_o
);
  always_comb begin
    sel_o.neg = digit_i[2];
    sel_o.one = digit_i[0];
    sel_o.two = digit_i[1] & ~digit_i[0];
  end
endmodule

// File: rtl/smb_recoder.sv
module smb_recoder #(
  parameter int WIDTH      = 8,
  parameter bit SIGNED_OPS = 1'b1,
  parameter int ND         = smb_pkg::digit_count(WIDTH, SIGNED_OPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [ND-1:0]    one_o,
  output logic [ND-1:0]    two_o,
  output logic [ND-1:0]    neg_o
);
  localparam int EXT = 2 * ND;

  logic [EXT-1:0]      a_ext, b_ext;
  logic [ND-1:0]       hc_c, k_c;
  logic signed [2:0]   digit [ND];
  smb_pkg::booth_sel_t sel   [ND];
  int                  exp_sum;
  int                  dec_sum;

  // Operand extension to a whole number of cells
  if (SIGNED_OPS) begin : g_sext
    assign a_ext   = {{(EXT-WIDTH){a_i[WIDTH-1]}}, a_i};
    assign b_ext   = {{(EXT-WIDTH){b_i[WIDTH-1]}}, b_i};
    assign exp_sum = int'($signed(a_i)) + int'($signed(b_i));
  end else begin : g_zext
    assign a_ext   = {{(EXT-WIDTH){1'b0}}, a_i};
    assign b_ext   = {{(EXT-WIDTH){1'b0}}, b_i};
    assign exp_sum = int'(a_i) + int'(b_i);
  end

  assign hc_c[0] = 1'b0;
  assign k_c[0]  = 1'b0;

  for (genvar j = 0; j < ND; j++) begin : g_cell
    if (SIGNED_OPS && j == ND - 1) begin : g_top
      smb_signed_top_cell u_cell (
        .a_lo(a_ext[2*j]), .a_hi(a_ext[2*j+1]),
        .b_lo(b_ext[2*j]), .b_hi(b_ext[2*j+1]),
        .hc_in(hc_c[j]), .k_in(k_c[j]), .digit_o(digit[j])
      );
    end else if (j == ND - 1) begin : g_last
      logic spill_hc, spill_k;
      smb_plain_cell u_cell (
        .a_lo(a_ext[2*j]), .a_hi(a_ext[2*j+1]),
        .b_lo(b_ext[2*j]), .b_hi(b_ext[2*j+1]),
        .hc_in(hc_c[j]), .k_in(k_c[j]),
        .hc_out(spill_hc), .k_out(spill_k), .digit_o(digit[j])
      );
      AST_NO_LOST_CARRY: assert property (@(posedge clk) disable iff (rst)
        !(spill_hc | spill_k)); // R3
    end else begin : g_mid
      smb_plain_cell u_cell (
        .a_lo(a_ext[2*j]), .a_hi(a_ext[2*j+1]),
        .b_lo(b_ext[2*j]), .b_hi(b_ext[2*j+1]),
        .hc_in(hc_c[j]), .k_in(k_c[j]),
        .hc_out(hc_c[j+1]), .k_out(k_c[j+1]), .digit_o(digit[j])
      );
    end
    smb_digit_enc u_enc (.digit_i(digit[j]), .sel_o(sel[j]));
  end

  // Registered select outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      one_o <= '0;
      two_o <= '0;
      neg_o <= '0;
    end else begin
      for (int j = 0; j < ND; j++) begin
        one_o[j] <= sel[j].one;
        two_o[j] <= sel[j].two;
        neg_o[j] <= sel[j].neg;
      end
    end
  end

  // Value carried by the registered digits
  always_comb begin
    int w;
    int m;
    dec_sum = 0;
    w = 1;
    for (int j = 0; j < ND; j++) begin
      m = two_o[j] ? 2 : (one_o[j] ? 1 : 0);
      dec_sum = dec_sum + (neg_o[j] ? -m : m) * w;
      w = w * 4;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (one_o == '0 && two_o == '0 && neg_o == '0)); // R8
  AST_ONE_TWO_EXCL: assert property (@(posedge clk) disable iff (rst)
    (one_o & two_o) == '0); // R4
  AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (neg_o & ~(one_o | two_o)) == '0); // R5

  if (SIGNED_OPS) begin : g_chk_s
    AST_SUM_SIGNED: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (dec_sum == $past(exp_sum))); // R2
  end else begin : g_chk_u
    AST_SUM_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (dec_sum == $past(exp_sum))); // R3
    AST_TOP_NONNEG: assert property (@(posedge clk) disable iff (rst)
      !neg_o[ND-1]); // R6
  end
endmodule

// File: tb/smb_recoder_tb_top.sv
module smb_recoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk; // 200 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [4:0] a_s5 = '0, b_s5 = '0;
  logic [3:0] a_s4 = '0, b_s4 = '0;
  logic [3:0] a_u4 = '0, b_u4 = '0;
  logic [4:0] a_u5 = '0, b_u5 = '0;
  logic [2:0] one_s5, two_s5, neg_s5;
  logic [2:0] one_s4, two_s4, neg_s4;
  logic [2:0] one_u4, two_u4, neg_u4;
  logic [3:0] one_u5, two_u5, neg_u5;

  smb_recoder #(.WIDTH(5), .SIGNED_OPS(1'b1)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_s5), .b_i(b_s5),
    .one_o(one_s5), .two_o(two_s5), .neg_o(neg_s5));
  smb_recoder #(.WIDTH(4), .SIGNED_OPS(1'b1)) dut_s4_i (
    .clk(clk), .rst(rst), .a_i(a_s4), .b_i(b_s4),
    .one_o(one_s4), .two_o(two_s4), .neg_o(neg_s4));
  smb_recoder #(.WIDTH(4), .SIGNED_OPS(1'b0)) dut_u4_i (
    .clk(clk), .rst(rst), .a_i(a_u4), .b_i(b_u4),
    .one_o(one_u4), .two_o(two_u4), .neg_o(neg_u4));
  smb_recoder #(.WIDTH(5), .SIGNED_OPS(1'b0)) dut_u5_i (
    .clk(clk), .rst(rst), .a_i(a_u5), .b_i(b_u5),
    .one_o(one_u5), .two_o(two_u5), .neg_o(neg_u5));

  function automatic int digit_val(input logic o, input logic t, input logic n);
    int m;
    m = t ? 2 : (o ? 1 : 0);
    return n ? -m : m;
  endfunction

  function automatic int decode(input logic [3:0] o, input logic [3:0] t,
                                input logic [3:0] n, input int nd);
    int acc;
    int w;
    acc = 0;
    w = 1;
    for (int i = 0; i < nd; i++) begin
      acc = acc + digit_val(o[i], t[i], n[i]) * w;
      w = w * 4;
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Encoding rules on every digit of a 4-bit select group
  task automatic chk_enc(input logic [3:0] o, input logic [3:0] t, input logic [3:0] n, input int nd);
    for (int i = 0; i < nd; i++) begin
      chk(!(o[i] && t[i]), "R4 one/two exclusive", int'(o[i] & t[i]), 0);
      chk(!(n[i] && !o[i] && !t[i]), "R5 zero digit not negated", int'(n[i]), 0);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b1;
    a_s5 = 5'd9; b_s5 = 5'd13; a_u5 = 5'd31; b_u5 = 5'd31;
    repeat (2) @(negedge clk);
    chk({one_s5, two_s5, neg_s5} == '0, "R8 reset clears signed outputs", int'({one_s5, two_s5, neg_s5}), 0);
    chk({one_u5, two_u5, neg_u5} == '0, "R8 reset clears unsigned outputs", int'({one_u5, two_u5, neg_u5}), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_widths;
    chk($bits(dut_i.one_o) == 3, "R1 digits signed w5", $bits(dut_i.one_o), 3);
    chk($bits(dut_s4_i.one_o) == 3, "R1 digits signed w4", $bits(dut_s4_i.one_o), 3);
    chk($bits(dut_u4_i.one_o) == 3, "R1 digits unsigned w4", $bits(dut_u4_i.one_o), 3);
    chk($bits(dut_u5_i.one_o) == 4, "R1 digits unsigned w5", $bits(dut_u5_i.one_o), 4);
  endtask

  task automatic test_latency;
    @(negedge clk); a_s5 = 5'd1; b_s5 = 5'd1;
    @(negedge clk); a_s5 = 5'd7; b_s5 = 5'd7;
    #1;
    chk(decode({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3) == 2, "R8 output holds before edge",
        decode({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3), 2);
    @(negedge clk);
    chk(decode({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3) == 14, "R8 output after one edge",
        decode({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3), 14);
  endtask

  task automatic test_sweep_s5;
    for (int x = -16; x < 16; x++) begin
      for (int y = -16; y < 16; y++) begin
        int got;
        @(negedge clk); a_s5 = x[4:0]; b_s5 = y[4:0];
        @(negedge clk);
        got = decode({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3);
        chk(got == x + y, "R2 signed w5 sum", got, x + y);
        chk_enc({1'b0, one_s5}, {1'b0, two_s5}, {1'b0, neg_s5}, 3);
      end
    end
  endtask

  task automatic test_sweep_s4;
    for (int x = -8; x < 8; x++) begin
      for (int y = -8; y < 8; y++) begin
        int got;
        @(negedge clk); a_s4 = x[3:0]; b_s4 = y[3:0];
        @(negedge clk);
        got = decode({1'b0, one_s4}, {1'b0, two_s4}, {1'b0, neg_s4}, 3);
        chk(got == x + y, "R2 signed w4 sum", got, x + y);
        chk_enc({1'b0, one_s4}, {1'b0, two_s4}, {1'b0, neg_s4}, 3);
      end
    end
  endtask

  task automatic test_sweep_u4;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        int got;
        @(negedge clk); a_u4 = x[3:0]; b_u4 = y[3:0];
        @(negedge clk);
        got = decode({1'b0, one_u4}, {1'b0, two_u4}, {1'b0, neg_u4}, 3);
        chk(got == x + y, "R3 unsigned w4 sum", got, x + y);
        chk(!neg_u4[2], "R6 unsigned w4 top digit", int'(neg_u4[2]), 0);
        chk_enc({1'b0, one_u4}, {1'b0, two_u4}, {1'b0, neg_u4}, 3);
      end
    end
  endtask

  task automatic test_sweep_u5;
    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        int got;
        @(negedge clk); a_u5 = x[4:0]; b_u5 = y[4:0];
        @(negedge clk);
        got = decode(one_u5, two_u5, neg_u5, 4);
        chk(got == x + y, "R3 unsigned w5 sum", got, x + y);
        chk(!neg_u5[3], "R6 unsigned w5 top digit", int'(neg_u5[3]), 0);
        chk_enc(one_u5, two_u5, neg_u5, 4);
      end
    end
  endtask

  // Sums at the edge of the range need the top digit
  task automatic test_extremes;
    @(negedge clk); a_s5 = 5'b10000; b_s5 = 5'b10000;
    @(negedge clk);
    chk(digit_val(one_s5[2], two_s5[2], neg_s5[2]) == -2, "R1 signed -32 top digit",
        digit_val(one_s5[2], two_s5[2], neg_s5[2]), -2);
    @(negedge clk); a_u5 = 5'd31; b_u5 = 5'd31;
    @(negedge clk);
    chk(digit_val(one_u5[3], two_u5[3], neg_u5[3]) > 0, "R1 unsigned 62 uses top digit",
        digit_val(one_u5[3], two_u5[3], neg_u5[3]), 1);
  endtask

  // Digit 2 ignores bit 0; digit 0 ignores bits 2 and up (signed w5)
  task automatic test_locality;
    for (int x = -16; x < 16; x++) begin
      for (int y = -16; y < 16; y += 5) begin
        int d2_ref, d0_ref, d2_alt, d0_alt;
        @(negedge clk); a_s5 = x[4:0]; b_s5 = y[4:0];
        @(negedge clk);
        d2_ref = digit_val(one_s5[2], two_s5[2], neg_s5[2]);
        d0_ref = digit_val(one_s5[0], two_s5[0], neg_s5[0]);
        a_s5 = x[4:0] ^ 5'b00001; b_s5 = y[4:0] ^ 5'b00001;
        @(negedge clk);
        d2_alt = digit_val(one_s5[2], two_s5[2], neg_s5[2]);
        chk(d2_alt == d2_ref, "R7 digit 2 ignores bit 0", d2_alt, d2_ref);
        a_s5 = x[4:0] ^ 5'b10100; b_s5 = y[4:0] ^ 5'b01100;
        @(negedge clk);
        d0_alt = digit_val(one_s5[0], two_s5[0], neg_s5[0]);
        chk(d0_alt == d0_ref, "R7 digit 0 ignores bits 4:2", d0_alt, d0_ref);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_widths();
    test_latency();
    test_sweep_s5();
    test_sweep_s4();
    test_sweep_u4();
    test_sweep_u5();
    test_extremes();
    test_locality();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule